// File: doc/BRIEF.md
# Memory Strobe Timing Generator

This block produces the active-low output-enable and write-enable strobes for one access to an external memory. A one-cycle start pulse begins the access. On that same edge the block captures the read/write flag, the address/data-multiplexed flag and a packed 32-bit timing word. A five-bit tick counter then runs from zero and stops at 31. Each strobe is low in the ticks that fall inside its programmed on/off window.

Either strobe can be moved half a clock later through its own delay bit. In multiplexed mode a read gets two output-enable pulses. The first is timed by a separate short window. After a gap with the strobe high comes the main read pulse. The address-drive flag stays high until the main output-enable on tick.

The block has no data stream, so there is no valid/ready handshake and no back-pressure: every pin is a plain control or status level. The start pulse is taken on any cycle, and a new start cuts short the access in progress.

Top module: `mem_strobe_gen`

## Requirements
- R1: Tick t is the clock cycle that begins t edges after the edge that samples `start` high, so tick 0 follows that edge. The counter counts 0, 1, 2 and so on, one per clock, and stays at 31. A new `start` clears it to 0 at any time.
- R2: On a read with `mux_mode` low, `oe_n` is low in exactly the ticks with rd_on <= t < rd_off, where rd_on = cfg[3:0] and rd_off = cfg[12:8]. An empty window (rd_on >= rd_off) gives no pulse.
- R3: On a write, `we_n` is low in exactly the ticks with wr_on <= t < wr_off, where wr_on = cfg[19:16] and wr_off = cfg[28:24]. `we_n` never goes low on a read, and `oe_n` never goes low on a write with `mux_mode` low.
- R4: With cfg[7] set, every `oe_n` edge comes half a clock period after the rising edge at which it would otherwise occur. The level seen late in each tick is unchanged.
- R5: With cfg[23] set, every `we_n` edge comes half a clock period later in the same way.
- R6: On a read with `mux_mode` high, `oe_n` is also low in the ticks with ad_on <= t < ad_off, where ad_on = cfg[6:4] and ad_off = cfg[15:13]. This is in addition to the R2 window.
- R7: On a write with `mux_mode` high, the only `oe_n` pulse covers ad_on <= t < ad_off, and `we_n` follows R3.
- R8: `addr_drive` is high in ticks t < rd_on of a read with `mux_mode` high, and low at all other times.
- R9: `cfg_err` is high exactly when the `mux_mode` input is high and cfg[15:13] >= cfg[3:0]. It is computed from the present inputs.
- R10: During and after reset, before any start, `oe_n` and `we_n` are high and `addr_drive` is low.
- R11: The timing word and both flags are captured at `start`. Changing them later in the access has no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | functional clock |
| rst_n | input | 1 | asynchronous active-low reset |
| start | input | 1 | one-cycle access start |
| is_write | input | 1 | 1 = write access, 0 = read |
| mux_mode | input | 1 | address/data-multiplexed device |
| cfg | input | 32 | packed timing word |
| oe_n | output | 1 | output-enable strobe, active low |
| we_n | output | 1 | write-enable strobe, active low |
| addr_drive | output | 1 | drive the address onto the shared bus |
| cfg_err | output | 1 | multiplexed first-pulse window overlaps main on tick |

## Verification
The hardest case to reach is the half-period delay. Its only visible effect lies between the rising and falling clock edges, so a bench that samples once per cycle cannot tell a delayed strobe from a plain one. The scoreboard therefore holds two expected values for each tick. It samples one a quarter period after the rising edge, where a delayed strobe still shows the previous tick's level, and the other after the falling edge. Multiplexed reads then combine the delay with two pulses and the address window. Each access also scrambles the inputs after the start pulse, so any read-through of live inputs shows up.

// File: rtl/mstrobe_pkg.sv
package mstrobe_pkg;
  localparam int TICK_W   = 5;
  localparam int TICK_MAX = (1 << TICK_W) - 1;
  localparam int N_STB    = 2;   // strobe index: 0 = output enable, 1 = write enable

  typedef logic [TICK_W-1:0] tick_t;

  typedef struct packed {
    tick_t rd_on;
    tick_t rd_off;
    tick_t wr_on;
    tick_t wr_off;
    tick_t ad_on;
    tick_t ad_off;
    logic  rd_half;
    logic  wr_half;
  } tcfg_t;
endpackage

// File: rtl/mstrobe_tick_counter.sv
module mstrobe_tick_counter
  import mstrobe_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  output tick_t cnt_nxt,
  output tick_t cnt_q
);
  localparam tick_t SAT = tick_t'(TICK_MAX);

  always_comb begin
    if (start)           cnt_nxt = '0;
    else if (cnt_q == SAT) cnt_nxt = SAT;
    else                 cnt_nxt = cnt_q + tick_t'(1);
  end

  // reset to the saturated value: idle looks like a finished access
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= SAT;
    else        cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/mstrobe_window.sv
module mstrobe_window
  import mstrobe_pkg::*;
(
  input  tick_t t,
  input  tick_t t_on,
  input  tick_t t_off,
  output logic  hit
);
  assign hit = (t >= t_on) && (t < t_off);
endmodule

// File: rtl/mstrobe_half_delay.sv
module mstrobe_half_delay (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic half,
  output logic pos_q,
  output logic pin_n
);
  logic neg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= 1'b0;
    else        pos_q <= level;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) neg_q <= 1'b0;
    else        neg_q <= pos_q;
  end

  assign pin_n = ~(half ? neg_q : pos_q);
endmodule

// File: rtl/mem_strobe_gen.sv
module mem_strobe_gen
  import mstrobe_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        is_write,
  input  logic        mux_mode,
  input  logic [31:0] cfg,
  output logic        oe_n,
  output logic        we_n,
  output logic        addr_drive,
  output logic        cfg_err
);
  tcfg_t cfg_in, cfg_q, cfg_nxt;
  logic  wr_q, wr_nxt, mux_q, mux_nxt;
  tick_t cnt_nxt, cnt_q;
  logic  hit_rd, hit_wr, hit_ad;
  logic  addr_q;
  logic [5:0] unused_cfg_bits;

  logic [N_STB-1:0] stb_level, stb_half, stb_pos, stb_pin;

  // field unpacking of the timing word
  assign cfg_in.rd_on   = tick_t'(cfg[3:0]);
  assign cfg_in.ad_on   = tick_t'(cfg[6:4]);
  assign cfg_in.rd_half = cfg[7];
  assign cfg_in.rd_off  = cfg[12:8];
  assign cfg_in.ad_off  = tick_t'(cfg[15:13]);
  assign cfg_in.wr_on   = tick_t'(cfg[19:16]);
  assign cfg_in.wr_half = cfg[23];
  assign cfg_in.wr_off  = cfg[28:24];
  assign unused_cfg_bits = {cfg[31:29], cfg[22:20]};

  assign cfg_err = mux_mode && (cfg_in.ad_off >= cfg_in.rd_on);

  // access context captured on start
  assign cfg_nxt = start ? cfg_in   : cfg_q;
  assign wr_nxt  = start ? is_write : wr_q;
  assign mux_nxt = start ? mux_mode : mux_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      wr_q  <= 1'b0;
      mux_q <= 1'b0;
    end else begin
      cfg_q <= cfg_nxt;
      wr_q  <= wr_nxt;
      mux_q <= mux_nxt;
    end
  end

  mstrobe_tick_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cnt_nxt(cnt_nxt), .cnt_q(cnt_q)
  );

  mstrobe_window u_win_rd (.t(cnt_nxt), .t_on(cfg_nxt.rd_on), .t_off(cfg_nxt.rd_off), .hit(hit_rd));
  mstrobe_window u_win_wr (.t(cnt_nxt), .t_on(cfg_nxt.wr_on), .t_off(cfg_nxt.wr_off), .hit(hit_wr));
  mstrobe_window u_win_ad (.t(cnt_nxt), .t_on(cfg_nxt.ad_on), .t_off(cfg_nxt.ad_off), .hit(hit_ad));

  // strobe levels for the tick that starts at the next edge
  always_comb begin
    if (wr_nxt) stb_level[0] = mux_nxt && hit_ad;
    else        stb_level[0] = hit_rd || (mux_nxt && hit_ad);
    stb_level[1] = wr_nxt && hit_wr;
  end

  assign stb_half[0] = cfg_q.rd_half;
  assign stb_half[1] = cfg_q.wr_half;

  generate
    for (genvar s = 0; s < N_STB; s++) begin : g_stb
      mstrobe_half_delay u_dly (
        .clk(clk), .rst_n(rst_n),
        .level(stb_level[s]), .half(stb_half[s]),
        .pos_q(stb_pos[s]), .pin_n(stb_pin[s])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= 1'b0;
    else        addr_q <= mux_nxt && !wr_nxt && (cnt_nxt < cfg_nxt.rd_on);
  end

  assign oe_n       = stb_pin[0];
  assign we_n       = stb_pin[1];
  assign addr_drive = addr_q;
endmodule

// File: rtl/mstrobe_chk.sv
module mstrobe_chk
  import mstrobe_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  start,
  input tick_t cnt_q,
  input logic  wr_q,
  input logic  mux_q,
  input logic  oe_pos,
  input logic  we_pos,
  input logic  addr_drive
);
  localparam tick_t SAT = tick_t'(TICK_MAX);

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cnt_q == '0);                                                   // R1
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && cnt_q != SAT) |=> cnt_q == tick_t'($past(cnt_q) + tick_t'(1)));  // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && cnt_q == SAT) |=> cnt_q == SAT);                                // R1
  AST_WE_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_q |-> !we_pos);                                                       // R3
  AST_OE_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q && !mux_q) |-> !oe_pos);                                            // R3
  AST_ADDR_SCOPE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_drive |-> (mux_q && !wr_q));                                         // R8
endmodule

bind mem_strobe_gen mstrobe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cnt_q(cnt_q),
  .wr_q(wr_q), .mux_q(mux_q), .oe_pos(stb_pos[0]), .we_pos(stb_pos[1]),
  .addr_drive(addr_drive)
);

// File: tb/tb_mem_strobe_gen.sv
`timescale 1ns/1ps
module tb_mem_strobe_gen;
  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic rst_n = 1'b0, start = 1'b0, is_write = 1'b0, mux_mode = 1'b0;
  logic [31:0] cfg = '0;
  logic oe_n, we_n, addr_drive, cfg_err;

  mem_strobe_gen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_write(is_write),
    .mux_mode(mux_mode), .cfg(cfg), .oe_n(oe_n), .we_n(we_n),
    .addr_drive(addr_drive), .cfg_err(cfg_err)
  );

  typedef struct {
    logic  oe_e, oe_l, we_e, we_l, ad;
    int    t;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(string req, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int rd_on, int rd_off, bit rd_half,
                                     int wr_on, int wr_off, bit wr_half,
                                     int ad_on, int ad_off);
    logic [31:0] w = '0;
    w[3:0] = 4'(rd_on);   w[12:8] = 5'(rd_off); w[7] = rd_half;
    w[19:16] = 4'(wr_on); w[28:24] = 5'(wr_off); w[23] = wr_half;
    w[6:4] = 3'(ad_on);   w[15:13] = 3'(ad_off);
    return w;
  endfunction

  function automatic bit inwin(int t, int on, int off);
    return t >= on && t < off;
  endfunction

  // active-high levels for tick t; t < 0 means idle
  function automatic void model(int t, logic [31:0] c, bit wr, bit mx,
                                output bit oe, output bit we, output bit ad);
    int ti = (t > 31) ? 31 : t;
    oe = 0; we = 0; ad = 0;
    if (t < 0) return;
    if (wr) begin
      oe = mx && inwin(ti, c[6:4], c[15:13]);
      we = inwin(ti, c[19:16], c[28:24]);
    end else begin
      oe = inwin(ti, c[3:0], c[12:8]) || (mx && inwin(ti, c[6:4], c[15:13]));
      ad = mx && (ti < int'(c[3:0]));
    end
  endfunction

  task automatic run(string tag, logic [31:0] c, bit wr, bit mx);
    @(negedge clk);
    cfg = c; is_write = wr; mux_mode = mx; start = 1'b1;
    for (int t = 0; t < 36; t++) begin
      exp_t e;
      bit oc, wc, ac, op, wp, ap;
      model(t, c, wr, mx, oc, wc, ac);
      model(t - 1, c, wr, mx, op, wp, ap);
      e.oe_l = ~oc; e.we_l = ~wc; e.ad = ac;
      e.oe_e = c[7]  ? ~op : ~oc;
      e.we_e = c[23] ? ~wp : ~wc;
      e.t = t; e.tag = tag;
      q.push_back(e);
    end
    @(negedge clk);
    start = 1'b0;
    cfg = ~c; is_write = ~wr; mux_mode = ~mx;   // R11: must not disturb this access
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  // monitor: early sample before the falling edge, late sample after it
  always begin
    @(posedge clk);
    if (q.size() > 0) begin
      cur = q.pop_front();
      #1;
      chk(cur.tag, $sformatf("oe_n early t=%0d", cur.t), oe_n, cur.oe_e);
      chk(cur.tag, $sformatf("we_n early t=%0d", cur.t), we_n, cur.we_e);
      chk(cur.tag, $sformatf("addr_drive t=%0d", cur.t), addr_drive, cur.ad);
      #2;
      chk(cur.tag, $sformatf("oe_n late t=%0d", cur.t), oe_n, cur.oe_l);
      chk(cur.tag, $sformatf("we_n late t=%0d", cur.t), we_n, cur.we_l);
    end
  end

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #5;
    chk("R10", "oe_n in reset", oe_n, 1'b1);
    chk("R10", "we_n in reset", we_n, 1'b1);
    chk("R10", "addr_drive in reset", addr_drive, 1'b0);
    #6 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10", "oe_n idle", oe_n, 1'b1);
    chk("R10", "we_n idle", we_n, 1'b1);

    // R9 combinational flag
    mux_mode = 1'b1; cfg = mk(3, 8, 0, 0, 0, 0, 1, 3); #1;
    chk("R9", "cfg_err off==on", cfg_err, 1'b1);
    cfg = mk(3, 8, 0, 0, 0, 0, 1, 2); #1;
    chk("R9", "cfg_err off<on", cfg_err, 1'b0);
    mux_mode = 1'b0; cfg = mk(3, 8, 0, 0, 0, 0, 1, 3); #1;
    chk("R9", "cfg_err non-mux", cfg_err, 1'b0);

    run("R2",      mk(2, 6, 0, 0, 0, 0, 0, 0), 0, 0);
    run("R1/R2",   mk(0, 31, 0, 3, 9, 0, 0, 0), 0, 0);
    run("R2 empty", mk(6, 6, 0, 0, 0, 0, 0, 0), 0, 0);
    run("R4",      mk(3, 7, 1, 0, 0, 0, 0, 0), 0, 0);
    run("R3",      mk(2, 6, 0, 1, 5, 0, 0, 0), 1, 0);
    run("R5",      mk(0, 0, 0, 4, 10, 1, 0, 0), 1, 0);
    run("R6/R8",   mk(5, 9, 0, 0, 0, 0, 1, 3), 0, 1);
    run("R6/R4",   mk(6, 11, 1, 0, 0, 0, 0, 4), 0, 1);
    run("R7",      mk(5, 9, 0, 3, 7, 0, 2, 4), 1, 1);
    run("R11",     mk(15, 31, 1, 15, 31, 1, 7, 7), 0, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule